// File: doc/BRIEF.md
# Serial Configuration Register Target

This block is a target-only serial port on a two-wire bus (I2C, standard mode, up to 100 kbit/s). It holds a bank of 8-bit configuration registers and presents every register value in parallel to the rest of the chip. A bus controller writes the bank by sending the write device address, one sub-address byte that loads an internal pointer, and then any number of data bytes. It reads the bank by loading the pointer the same way, issuing a repeated start with the read device address, and clocking out bytes. The pointer steps by one after every byte in either direction. After the last register it wraps back to the first.

Both bus lines are oversampled in the system clock domain through two-stage synchronizers. Start and stop are recognized as a change on the data line while the clock line is high. The data line is open drain: the block only ever pulls it low through a drive enable. The top register is a fixed identification code. The block acknowledges writes to it but does not store them. A write to the low byte of the chroma clock-ratio pair raises a one-cycle strobe, so that downstream logic can restart its acquisition.

Top module: `cfg_i2c_target`

## Requirements
- R1: After the active-low reset, every register holds its default and SDA is released. The defaults are 0x80 at 0x05, 0xBD at 0x06, 0x9D at 0x07, 0x87 at 0x0C, 0xC1 at 0x0D, 0x12 at 0x1B, and 0x00 everywhere else. Register n appears on `regs_o[8n+7:8n]`.
- R2: The block pulls SDA low in the ninth clock of an address byte only for 0x88 (write) and 0x89 (read). Any other address, including the general call 0x00, gets no acknowledge, and the following bytes are ignored until the next start.
- R3: In a write, the first byte after the address loads the pointer. Each later byte is acknowledged, stored at the pointer, and the pointer then steps by one.
- R4: After the read address, bytes are sent MSB first from the current pointer, and the pointer steps by one after each byte. A read without a preceding sub-address continues from wherever the pointer was left.
- R5: The pointer wraps from 0x1B to 0x00, both when writing and when reading.
- R6: Register 0x1B always reads 0x12. A write to it is acknowledged but changes nothing.
- R7: `ratio_wr_pulse` is high for exactly one cycle after each write to register 0x0D, and never after writes to other registers.
- R8: When the controller does not acknowledge a read byte, the block releases SDA and stays off the bus until the next start or stop.
- R9: A sub-address of 0x1C or above loads the pointer with 0x00.
- R10: A stop in the middle of a byte abandons that byte: nothing is written and the pointer keeps its value.
- R11: The block changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | When high, pull the data line low |
| regs_o | output | NUM_REGS*8 | All register values, register n at bits 8n+7:8n |
| ratio_wr_pulse | output | 1 | One-cycle strobe after a write to the ratio low byte |

## Verification
Writes are tried as multi-byte bursts at a mid-bank pointer, across the wrap point that passes through the identification register, and with an out-of-range sub-address. Together these separate correct stepping from wrapping and from clamping. Reads are tried after a fresh sub-address, continuing from a pointer left by an earlier transfer, and across the wrap. A read after a refused acknowledge, with the controller leaving the line high, shows whether the block really let go of SDA. A foreign address, the general call, and a byte cut short by a stop each show that nothing was stored. The strobe is counted over writes that touch the ratio byte alone, the neighbouring byte alone, and both bytes in one burst.

// File: rtl/cfg_i2c_pkg.sv
package cfg_i2c_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_SUB,
    ST_SUB_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_TX,
    ST_MACK
  } bus_state_e;

  // Power-up value of each writable register.
  function automatic logic [7:0] reg_default(input int idx);
    case (idx)
      5:       reg_default = 8'h80;  // luma offset, midpoint
      6:       reg_default = 8'hBD;  // luma gain
      7:       reg_default = 8'h9D;  // chroma gain
      12:      reg_default = 8'h87;  // clock ratio, high byte
      13:      reg_default = 8'hC1;  // clock ratio, low byte
      default: reg_default = 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/cfg_i2c_line_sync.sv
module cfg_i2c_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);

  logic [SYNC_STAGES-1:0] scl_pipe, sda_pipe;
  logic                   scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
      scl_d    <= scl_pipe[SYNC_STAGES-1];
      sda_d    <= sda_pipe[SYNC_STAGES-1];
    end
  end

  assign scl_lvl   = scl_pipe[SYNC_STAGES-1];
  assign sda_lvl   = sda_pipe[SYNC_STAGES-1];
  assign scl_rise  = scl_lvl & ~scl_d;
  assign scl_fall  = ~scl_lvl & scl_d;
  assign start_evt = scl_lvl & scl_d & sda_d & ~sda_lvl;
  assign stop_evt  = scl_lvl & scl_d & ~sda_d & sda_lvl;

endmodule

// File: rtl/cfg_i2c_engine.sv
module cfg_i2c_engine
  import cfg_i2c_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR7 = 7'h44
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sda_lvl,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_evt,
  input  logic       stop_evt,
  input  logic [7:0] rd_data,
  output logic       sda_oe,
  output logic       ptr_load,
  output logic       ptr_step,
  output logic       wr_en,
  output logic [7:0] rx_byte,
  output bus_state_e state
);

  bus_state_e state_q, state_n;
  logic [3:0] bit_q, bit_n;
  logic [7:0] rx_q, rx_n;
  logic [7:0] tx_q, tx_n;
  logic       oe_q, oe_n;
  logic       rw_q, rw_n;
  logic       mack_q, mack_n;

  always_comb begin
    state_n  = state_q;
    bit_n    = bit_q;
    rx_n     = rx_q;
    tx_n     = tx_q;
    oe_n     = oe_q;
    rw_n     = rw_q;
    mack_n   = mack_q;
    ptr_load = 1'b0;
    ptr_step = 1'b0;
    wr_en    = 1'b0;
    if (stop_evt) begin
      state_n = ST_IDLE;
      oe_n    = 1'b0;
    end else if (start_evt) begin
      state_n = ST_ADDR;
      bit_n   = '0;
      oe_n    = 1'b0;
    end else begin
      case (state_q)
        ST_ADDR, ST_SUB, ST_WR: begin
          if (scl_rise) begin
            rx_n  = {rx_q[6:0], sda_lvl};
            bit_n = bit_q + 4'd1;
          end else if (scl_fall && bit_q == 4'd8) begin
            bit_n = '0;
            if (state_q == ST_ADDR) begin
              if (rx_q[7:1] == DEV_ADDR7) begin
                rw_n    = rx_q[0];
                oe_n    = 1'b1;
                state_n = ST_ADDR_ACK;
              end else begin
                state_n = ST_IDLE;
              end
            end else if (state_q == ST_SUB) begin
              ptr_load = 1'b1;
              oe_n     = 1'b1;
              state_n  = ST_SUB_ACK;
            end else begin
              wr_en    = 1'b1;
              ptr_step = 1'b1;
              oe_n     = 1'b1;
              state_n  = ST_WR_ACK;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall) begin
            bit_n = '0;
            if (rw_q) begin
              tx_n    = rd_data;
              oe_n    = ~rd_data[7];
              state_n = ST_TX;
            end else begin
              oe_n    = 1'b0;
              state_n = ST_SUB;
            end
          end
        end
        ST_SUB_ACK, ST_WR_ACK: begin
          if (scl_fall) begin
            oe_n    = 1'b0;
            bit_n   = '0;
            state_n = ST_WR;
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (bit_q == 4'd7) begin
              oe_n     = 1'b0;
              ptr_step = 1'b1;
              state_n  = ST_MACK;
            end else begin
              tx_n  = {tx_q[6:0], 1'b0};
              oe_n  = ~tx_q[6];
              bit_n = bit_q + 4'd1;
            end
          end
        end
        ST_MACK: begin
          if (scl_rise) begin
            mack_n = ~sda_lvl;
          end else if (scl_fall) begin
            bit_n = '0;
            if (mack_q) begin
              tx_n    = rd_data;
              oe_n    = ~rd_data[7];
              state_n = ST_TX;
            end else begin
              state_n = ST_IDLE;
            end
          end
        end
        default: state_n = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      bit_q   <= '0;
      rx_q    <= '0;
      tx_q    <= '0;
      oe_q    <= 1'b0;
      rw_q    <= 1'b0;
      mack_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      bit_q   <= bit_n;
      rx_q    <= rx_n;
      tx_q    <= tx_n;
      oe_q    <= oe_n;
      rw_q    <= rw_n;
      mack_q  <= mack_n;
    end
  end

  assign sda_oe  = oe_q;
  assign rx_byte = rx_q;
  assign state   = state_q;

endmodule

// File: rtl/cfg_i2c_bank.sv
module cfg_i2c_bank
  import cfg_i2c_pkg::*;
#(
  parameter int         NUM_REGS  = 28,
  parameter logic [7:0] ID_VALUE  = 8'h12,
  parameter int         RATIO_IDX = 13,
  localparam int        PTR_W     = $clog2(NUM_REGS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ptr_load,
  input  logic                  ptr_step,
  input  logic                  wr_en,
  input  logic [7:0]            byte_i,
  output logic [7:0]            rd_data,
  output logic [PTR_W-1:0]      ptr,
  output logic [NUM_REGS*8-1:0] regs_o,
  output logic                  ratio_pulse
);

  localparam logic [PTR_W-1:0] LAST_P  = PTR_W'(NUM_REGS - 1);
  localparam logic [PTR_W-1:0] RATIO_P = PTR_W'(RATIO_IDX);

  logic [PTR_W-1:0] ptr_q;
  logic [7:0]       regs_q [NUM_REGS];
  logic             pulse_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (ptr_load) begin
      ptr_q <= (byte_i < 8'(NUM_REGS)) ? byte_i[PTR_W-1:0] : '0;
    end else if (ptr_step) begin
      ptr_q <= (ptr_q == LAST_P) ? '0 : ptr_q + PTR_W'(1);
    end
  end

  generate
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
      if (i == NUM_REGS - 1) begin : g_id
        assign regs_q[i] = ID_VALUE;
      end else begin : g_rw
        logic sel;
        assign sel = wr_en && (ptr_q == PTR_W'(i));
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            regs_q[i] <= reg_default(i);
          end else if (sel) begin
            regs_q[i] <= byte_i;
          end
        end
      end
      assign regs_o[i*8 +: 8] = regs_q[i];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= wr_en && (ptr_q == RATIO_P);
    end
  end

  assign rd_data     = regs_q[ptr_q];
  assign ptr         = ptr_q;
  assign ratio_pulse = pulse_q;

endmodule

// File: rtl/cfg_i2c_target.sv
module cfg_i2c_target
  import cfg_i2c_pkg::*;
#(
  parameter int         NUM_REGS    = 28,
  parameter logic [6:0] DEV_ADDR7   = 7'h44,
  parameter logic [7:0] ID_VALUE    = 8'h12,
  parameter int         RATIO_IDX   = 13,
  parameter int         SYNC_STAGES = 2,
  localparam int        PTR_W       = $clog2(NUM_REGS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe,
  output logic [NUM_REGS*8-1:0] regs_o,
  output logic                  ratio_wr_pulse
);

  logic       rst_meta, rst_n_s;
  logic       scl_lvl, sda_lvl, scl_rise, scl_fall, start_evt, stop_evt;
  logic       ptr_load, ptr_step, wr_en;
  logic [7:0] rx_byte, rd_data;
  logic [PTR_W-1:0] cur_ptr;
  bus_state_e eng_state;

  // Reset asserts at once and releases on a clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_n_s  <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_n_s  <= rst_meta;
    end
  end

  cfg_i2c_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n_s), .scl_i(scl_i), .sda_i(sda_i),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_evt(start_evt), .stop_evt(stop_evt)
  );

  cfg_i2c_engine #(.DEV_ADDR7(DEV_ADDR7)) u_eng (
    .clk(clk), .rst_n(rst_n_s), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_evt(start_evt), .stop_evt(stop_evt),
    .rd_data(rd_data), .sda_oe(sda_oe), .ptr_load(ptr_load),
    .ptr_step(ptr_step), .wr_en(wr_en), .rx_byte(rx_byte), .state(eng_state)
  );

  cfg_i2c_bank #(.NUM_REGS(NUM_REGS), .ID_VALUE(ID_VALUE), .RATIO_IDX(RATIO_IDX)) u_bank (
    .clk(clk), .rst_n(rst_n_s), .ptr_load(ptr_load), .ptr_step(ptr_step),
    .wr_en(wr_en), .byte_i(rx_byte), .rd_data(rd_data), .ptr(cur_ptr),
    .regs_o(regs_o), .ratio_pulse(ratio_wr_pulse)
  );

endmodule

// File: rtl/cfg_i2c_target_chk.sv
module cfg_i2c_target_chk
  import cfg_i2c_pkg::*;
#(
  parameter int  NUM_REGS  = 28,
  parameter int  RATIO_IDX = 13,
  localparam int PTR_W     = $clog2(NUM_REGS)
) (
  input logic                  clk,
  input logic                  rst_n_s,
  input logic                  scl_lvl,
  input logic                  sda_oe,
  input logic                  wr_en,
  input logic [PTR_W-1:0]      cur_ptr,
  input logic [NUM_REGS*8-1:0] regs_o,
  input logic                  ratio_wr_pulse,
  input bus_state_e            eng_state
);

  AST_DRIVE_ONLY_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(sda_oe) |-> !scl_lvl); // R11

  AST_PTR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n_s)
    cur_ptr < PTR_W'(NUM_REGS)); // R5

  AST_REGS_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n_s)
    !wr_en |=> $stable(regs_o)); // R3

  AST_PULSE_FROM_RATIO_WRITE: assert property (@(posedge clk) disable iff (!rst_n_s)
    ratio_wr_pulse |-> ($past(wr_en) && $past(cur_ptr) == PTR_W'(RATIO_IDX))); // R7

  AST_PULSE_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n_s)
    ratio_wr_pulse |=> !ratio_wr_pulse); // R7

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n_s)
    (eng_state == ST_IDLE) |-> !sda_oe); // R8

endmodule

bind cfg_i2c_target cfg_i2c_target_chk #(.NUM_REGS(NUM_REGS), .RATIO_IDX(RATIO_IDX)) u_chk (
  .clk(clk), .rst_n_s(rst_n_s), .scl_lvl(scl_lvl), .sda_oe(sda_oe),
  .wr_en(wr_en), .cur_ptr(cur_ptr), .regs_o(regs_o),
  .ratio_wr_pulse(ratio_wr_pulse), .eng_state(eng_state)
);

// File: tb/tb_cfg_i2c_target.sv
`timescale 1ns/1ps
module tb_cfg_i2c_target;

  localparam int NR = 28;
  localparam int Q  = 25;

  logic clk = 1'b0;
  logic rst_n;
  logic scl_m, sda_m;
  logic sda_oe, ratio_wr_pulse;
  logic [NR*8-1:0] regs_o;
  wire  sda_bus = sda_m & ~sda_oe;

  int checks = 0, fails = 0, pulses = 0, drive_viol = 0;
  bit done = 0;
  logic [7:0] exp_r [NR];
  logic scl_prev = 1'b1, oe_prev = 1'b0;

  always #2.5 clk = ~clk;

  cfg_i2c_target dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_oe(sda_oe), .regs_o(regs_o), .ratio_wr_pulse(ratio_wr_pulse)
  );

  always @(negedge clk) begin
    if (ratio_wr_pulse) pulses++;
    if (rst_n && scl_prev && scl_m && (sda_oe != oe_prev)) drive_viol++;
    scl_prev = scl_m;
    oe_prev  = sda_oe;
  end

  function automatic logic [7:0] dflt(input int i);
    if (i == 5) return 8'h80;
    if (i == 6) return 8'hBD;
    if (i == 7) return 8'h9D;
    if (i == 12) return 8'h87;
    if (i == 13) return 8'hC1;
    if (i == 27) return 8'h12;
    return 8'h00;
  endfunction

  task automatic chk(input string req, input int act, input int expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic wq(input int n = 1);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; wq(); scl_m = 1'b1; wq(2); scl_m = 1'b0; wq();
    end
  endtask

  task automatic wbyte(input logic [7:0] b, output logic ack);
    send_bits(b, 8);
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); ack = ~sda_bus; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic rbyte(input logic give_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq(); scl_m = 1'b1; wq(); b[i] = sda_bus; wq(); scl_m = 1'b0; wq();
    end
    sda_m = ~give_ack; wq(); scl_m = 1'b1; wq(2); scl_m = 1'b0; wq(); sda_m = 1'b1;
  endtask

  task automatic write_seq(input logic [7:0] sub, input logic [7:0] d[$]);
    logic a;
    bus_start();
    wbyte(8'h88, a); chk("R2 write address ack", a, 1);
    wbyte(sub, a);   chk("R3 sub-address ack", a, 1);
    foreach (d[k]) begin
      wbyte(d[k], a); chk("R3 data ack", a, 1);
    end
    bus_stop();
  endtask

  task automatic t_reset();
    chk("R1 sda released", sda_oe, 0);
    for (int i = 0; i < NR; i++) chk("R1 default", regs_o[i*8 +: 8], exp_r[i]);
  endtask

  task automatic t_write_burst();
    logic a; logic [7:0] b;
    write_seq(8'h10, '{8'h11, 8'h22, 8'h33});
    exp_r[16] = 8'h11; exp_r[17] = 8'h22; exp_r[18] = 8'h33;
    for (int i = 15; i < 20; i++) chk("R3 burst write", regs_o[i*8 +: 8], exp_r[i]);
    bus_start(); wbyte(8'h89, a); chk("R2 read address ack", a, 1);
    rbyte(1'b0, b); chk("R4 read continues at pointer", b, exp_r[19]);
    bus_stop();
  endtask

  task automatic t_read_burst();
    logic a; logic [7:0] b;
    bus_start(); wbyte(8'h88, a); wbyte(8'h05, a);
    bus_start(); wbyte(8'h89, a); chk("R4 read ack after repeated start", a, 1);
    rbyte(1'b1, b); chk("R4 read byte 0x05", b, exp_r[5]);
    rbyte(1'b1, b); chk("R4 read byte 0x06", b, exp_r[6]);
    rbyte(1'b0, b); chk("R4 read byte 0x07", b, exp_r[7]);
    bus_stop();
  endtask

  task automatic t_wrong_addr();
    logic a;
    bus_start();
    wbyte(8'h90, a); chk("R2 foreign address no ack", a, 0);
    wbyte(8'h04, a); chk("R2 ignored byte no ack", a, 0);
    wbyte(8'h5A, a); chk("R2 ignored byte no ack", a, 0);
    bus_stop();
    chk("R2 register untouched", regs_o[4*8 +: 8], exp_r[4]);
    bus_start();
    wbyte(8'h00, a); chk("R2 general call no ack", a, 0);
    wbyte(8'h6B, a); chk("R2 general call data no ack", a, 0);
    bus_stop();
    for (int i = 0; i < NR; i++) chk("R2 bank unchanged", regs_o[i*8 +: 8], exp_r[i]);
  endtask

  task automatic t_wrap();
    logic a; logic [7:0] b;
    write_seq(8'h1A, '{8'hAA, 8'h55, 8'h77});
    exp_r[26] = 8'hAA; exp_r[0] = 8'h77;
    chk("R5 write before wrap", regs_o[26*8 +: 8], 8'hAA);
    chk("R6 id write ignored", regs_o[27*8 +: 8], 8'h12);
    chk("R5 write after wrap", regs_o[0*8 +: 8], 8'h77);
    bus_start(); wbyte(8'h88, a); wbyte(8'h1A, a);
    bus_start(); wbyte(8'h89, a);
    rbyte(1'b1, b); chk("R5 read before wrap", b, 8'hAA);
    rbyte(1'b1, b); chk("R6 id reads 0x12", b, 8'h12);
    rbyte(1'b0, b); chk("R5 read after wrap", b, 8'h77);
    bus_stop();
  endtask

  task automatic t_pulse();
    int p0;
    p0 = pulses;
    write_seq(8'h0C, '{8'h90});
    exp_r[12] = 8'h90;
    chk("R7 no pulse for neighbour", pulses, p0);
    write_seq(8'h0D, '{8'h44});
    exp_r[13] = 8'h44;
    chk("R7 one pulse for ratio byte", pulses, p0 + 1);
    write_seq(8'h0C, '{8'h91, 8'h45});
    exp_r[12] = 8'h91; exp_r[13] = 8'h45;
    chk("R7 one pulse in burst", pulses, p0 + 2);
    chk("R7 ratio value", regs_o[13*8 +: 8], 8'h45);
  endtask

  task automatic t_nack();
    logic a; logic [7:0] b;
    bus_start(); wbyte(8'h88, a); wbyte(8'h05, a);
    bus_start(); wbyte(8'h89, a);
    rbyte(1'b0, b); chk("R8 byte before nack", b, exp_r[5]);
    rbyte(1'b0, b); chk("R8 line released after nack", b, 8'hFF);
    chk("R8 drive off", sda_oe, 0);
    bus_stop();
  endtask

  task automatic t_range();
    write_seq(8'h1F, '{8'h3C});
    exp_r[0] = 8'h3C;
    chk("R9 out-of-range sub-address to 0x00", regs_o[0*8 +: 8], 8'h3C);
    chk("R9 register 0x1F mod not hit", regs_o[3*8 +: 8], exp_r[3]);
  endtask

  task automatic t_abort();
    logic a; logic [7:0] b;
    bus_start(); wbyte(8'h88, a); wbyte(8'h08, a);
    send_bits(8'hF0, 4);
    bus_stop();
    chk("R10 partial byte not stored", regs_o[8*8 +: 8], exp_r[8]);
    bus_start(); wbyte(8'h89, a);
    rbyte(1'b0, b); chk("R10 pointer kept", b, exp_r[8]);
    bus_stop();
  endtask

  initial begin
    for (int i = 0; i < NR; i++) exp_r[i] = dflt(i);
    scl_m = 1'b1; sda_m = 1'b1; rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_write_burst();
    t_read_burst();
    t_wrong_addr();
    t_wrap();
    t_pulse();
    t_nack();
    t_range();
    t_abort();
    chk("R11 drive changes only with SCL low", drive_viol, 0);
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule